// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block is a direct-mapped data cache with one word per line. It sits between a processor's request port and a slower main-memory port. A load that finds its line present is answered from the cache. A load that does not find its line reads the word from memory, installs it in the line and returns it.

Every store is placed in a small FIFO that drains to memory in the background, so the processor can go on while the memory write is still pending. The cache therefore never holds a word that memory will not also receive. A store whose line is present also updates the cached word. A store whose line is absent goes only to memory and does not allocate a line.

The memory port carries one transaction at a time. Queued writes take the port whenever no line fill is running. A load miss lets the queue empty before it issues its read, so the read always sees the newest stored value.

Top module: `wt_cache`

## Requirements
- R1: A load whose line is present is accepted with `cpu_ready` high, returns the cached word with `cpu_rvalid` high on the cycle after acceptance, and issues no memory read.
- R2: A load whose line is absent issues one memory read at the word-aligned address (bits 1:0 zero). It returns `mem_rdata` with `cpu_rvalid` on the cycle after `mem_ack`, and it installs the line so that a later load to the same word is a hit.
- R3: Every accepted store yields exactly one memory write (`mem_we` high), with the stored data at the word-aligned address, in the order the stores were accepted.
- R4: A store whose line is present overwrites the cached word, so a later load to that word returns the new data without a memory read.
- R5: A store whose line is absent leaves the line's valid bit, tag and data unchanged. A load to the word already in that line still hits, and a load to the stored word misses.
- R6: When the store queue holds its full depth of entries, a store request sees `cpu_ready` low until an entry has been written to memory.
- R7: A load miss issues its memory read only after all earlier queued stores are written, so it returns the newest stored value of its word.
- R8: Once `mem_req` is raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is high.
- R9: After reset every line is invalid, `cpu_ready` is high, and `cpu_rvalid` and `mem_req` are low.
- R10: Address bits 1:0 are ignored. A load that differs from a resident word only in those bits hits and returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request accepted this cycle when high with cpu_req |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the current transaction |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The bench builds the cache with 8 lines (INDEX_W = 3) and a queue depth of 4. Addresses only 32 bytes apart then collide in one line, which makes the no-allocate case for store misses easy to set up. Four back-to-back stores are enough to fill the queue. The bench's memory latency can be changed between phases. A long latency keeps the first queued write in flight, so the full-queue stall and the read that waits behind queued writes both occur on known cycles.

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int INDEX_W    = 4,
  parameter int WBUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LINES  = 1 << INDEX_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - 2;
  localparam int WORD_W = ADDR_W - 2;
  localparam int PTR_W  = $clog2(WBUF_DEPTH);

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [WORD_W-1:0] wb_word [WBUF_DEPTH];
  logic [DATA_W-1:0] wb_data [WBUF_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [PTR_W:0]    count;

  logic              miss_q;
  logic [WORD_W-1:0] miss_word;

  logic unused_lsb;
  assign unused_lsb = ^cpu_addr[1:0];

  wire [INDEX_W-1:0] idx   = cpu_addr[2 +: INDEX_W];
  wire [TAG_W-1:0]   tag   = cpu_addr[ADDR_W-1 -: TAG_W];
  wire               hit   = valid_q[idx] && (tag_q[idx] == tag);
  wire [INDEX_W-1:0] m_idx = miss_word[0 +: INDEX_W];
  wire [TAG_W-1:0]   m_tag = miss_word[WORD_W-1 -: TAG_W];

  wire wb_full  = (count == (PTR_W+1)'(WBUF_DEPTH));
  wire wb_empty = (count == '0);

  assign cpu_ready = !miss_q && !(cpu_we && wb_full);
  wire accept    = cpu_req && cpu_ready;
  wire st_acc    = accept && cpu_we;
  wire ld_acc    = accept && !cpu_we;
  wire wr_done   = mem_ack && mem_we;
  wire fill_done = mem_ack && !mem_we;

  assign mem_req   = !wb_empty || miss_q;
  assign mem_we    = !wb_empty;
  assign mem_addr  = {(wb_empty ? miss_word : wb_word[rd_ptr]), 2'b00};
  assign mem_wdata = wb_data[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      miss_q     <= 1'b0;
      miss_word  <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      if (ld_acc) begin
        if (hit) begin
          cpu_rvalid <= 1'b1;
          cpu_rdata  <= data_q[idx];
        end else begin
          miss_q    <= 1'b1;
          miss_word <= cpu_addr[ADDR_W-1:2];
        end
      end
      if (st_acc) begin
        wb_word[wr_ptr] <= cpu_addr[ADDR_W-1:2];
        wb_data[wr_ptr] <= cpu_wdata;
        wr_ptr          <= wr_ptr + 1'b1;
        if (hit) data_q[idx] <= cpu_wdata;
      end
      if (wr_done) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (PTR_W+1)'(st_acc) - (PTR_W+1)'(wr_done);
      if (fill_done) begin
        valid_q[m_idx] <= 1'b1;
        tag_q[m_idx]   <= m_tag;
        data_q[m_idx]  <= mem_rdata;
        cpu_rvalid     <= 1'b1;
        cpu_rdata      <= mem_rdata;
        miss_q         <= 1'b0;
      end
    end
  end

  assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_acc && hit) |=> cpu_rvalid);

  assert_hit_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_acc && hit) |=> (data_q[$past(idx)] == $past(cpu_wdata)));

  assert_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_acc && !hit) |=> (valid_q == $past(valid_q)));

  assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && wb_full) |-> !cpu_ready);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PTR_W+1)'(WBUF_DEPTH));

  assert_read_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (miss_q && wb_empty));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/wt_cache_tb.sv
module wt_cache_tb;
  localparam int AW = 32, DW = 32, IW = 3, DEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  wt_cache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW), .WBUF_DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int checks = 0, errors = 0;
  int mem_lat = 2, lat_cnt = 0, rd_count = 0;
  logic [DW-1:0] memarr [int];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_ld [$];
  string         exp_tag [$];
  logic [AW+DW-1:0] exp_wr [$];
  logic [AW-1:0] t_addr;
  logic [DW-1:0] t_data;
  logic t_we, held_bad = 1'b0;

  function automatic logic [DW-1:0] init_val(int w);
    return (w * 32'h9E37) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [DW-1:0] mem_val(int w);
    return memarr.exists(w) ? memarr[w] : init_val(w);
  endfunction

  function automatic logic [DW-1:0] sh_val(int w);
    return shadow.exists(w) ? shadow[w] : init_val(w);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (rst_n && mem_req) begin
      if (lat_cnt == 0) begin
        t_addr = mem_addr; t_we = mem_we; t_data = mem_wdata;
      end else if (mem_addr !== t_addr || mem_we !== t_we || (t_we && mem_wdata !== t_data))
        held_bad = 1'b1;
      if (lat_cnt >= mem_lat) begin
        mem_ack = 1'b1;
        lat_cnt = 0;
        check(!held_bad, "R8 request held until ack", {63'd0, held_bad}, 64'd0);
        held_bad = 1'b0;
        if (t_we) begin
          if (exp_wr.size() == 0) check(1'b0, "R3 unexpected memory write", {32'd0, t_addr}, 64'd0);
          else check({t_addr, t_data} == exp_wr[0], "R3 write address/data/order", {t_addr, t_data}, exp_wr[0]);
          if (exp_wr.size() != 0) void'(exp_wr.pop_front());
          memarr[int'(t_addr >> 2)] = t_data;
        end else begin
          check(t_addr[1:0] == 2'b00, "R2 aligned read address", {32'd0, t_addr}, {32'd0, t_addr & ~32'd3});
          mem_rdata = mem_val(int'(t_addr >> 2));
          rd_count++;
        end
      end else lat_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_ld.size() == 0) check(1'b0, "R1 unexpected rvalid", {32'd0, cpu_rdata}, 64'd0);
      else begin
        check(cpu_rdata == exp_ld[0], exp_tag[0], {32'd0, cpu_rdata}, {32'd0, exp_ld[0]});
        void'(exp_ld.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string req, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    stalls = 0;
    while (!cpu_ready) begin
      @(negedge clk); #1; stalls++;
    end
    if (we) begin
      shadow[int'(a >> 2)] = d;
      exp_wr.push_back({a & ~32'd3, d});
    end else begin
      exp_ld.push_back(sh_val(int'(a >> 2)));
      exp_tag.push_back(req);
    end
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int s;
    access(1'b1, a, d, "R3", s);
  endtask

  task automatic load_chk(input logic [AW-1:0] a, input int exp_reads, input string req);
    int s, rc;
    rc = rd_count;
    access(1'b0, a, '0, req, s);
    while (exp_ld.size() != 0) @(negedge clk);
    check(rd_count - rc == exp_reads, req, 64'(rd_count - rc), 64'(exp_reads));
  endtask

  task automatic drain();
    while (exp_wr.size() != 0 || mem_req) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    logic [31:0] lcg;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready == 1'b1, "R9 ready after reset", 64'(cpu_ready), 64'd1);
    check(cpu_rvalid == 1'b0, "R9 rvalid after reset", 64'(cpu_rvalid), 64'd0);
    check(mem_req == 1'b0, "R9 mem_req after reset", 64'(mem_req), 64'd0);

    load_chk(32'h100, 1, "R9 R2 first load misses and fills");
    load_chk(32'h100, 0, "R1 load hit");
    load_chk(32'h103, 0, "R10 byte offset ignored");

    store(32'h100, 32'hDEAD_0001);
    load_chk(32'h100, 0, "R4 store hit updates cached word");
    drain();

    store(32'h120, 32'hBEEF_0002);
    load_chk(32'h100, 0, "R5 resident word still hits after store miss");
    load_chk(32'h120, 1, "R5 store miss did not allocate");
    load_chk(32'h120, 0, "R2 filled line then hits");

    mem_lat = 6;
    store(32'h200, 32'hCAFE_0003);
    store(32'h204, 32'hCAFE_0004);
    load_chk(32'h204, 1, "R7 load miss returns newest queued store");

    drain();
    mem_lat = 20;
    for (int i = 0; i < DEP; i++) begin
      access(1'b1, 32'h300 + 32'(4*i), 32'h1000 + 32'(i), "R6", s);
      check(s == 0, "R6 no stall below full", 64'(s), 64'd0);
    end
    access(1'b1, 32'h310, 32'h2000, "R6", s);
    check(s > 0, "R6 store stalls while queue full", 64'(s), 64'd1);
    drain();
    mem_lat = 1;
    load_chk(32'h310, 1, "R3 R7 stalled store reached memory");

    lcg = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      a = {22'd0, lcg[17:10], 2'b00};
      mem_lat = int'(lcg[21:20]);
      if (lcg[24]) store(a, lcg ^ 32'h0F0F_0F0F);
      else access(1'b0, a, '0, "R1 R2 R4 R7 mixed traffic", s);
    end
    while (exp_ld.size() != 0) @(negedge clk);
    drain();
    check(exp_wr.size() == 0, "R3 all stores written", 64'(exp_wr.size()), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule